// File: doc/BRIEF.md
# Indirect IO Register Window Bridge

This bridge gives a full register space access through an IO decode that is only eight bytes wide. The IO side has two dword windows. The pointer window sits at offset 0 and holds a byte offset into the internal register space. The data window sits at offset 4. A write to the data window becomes a register-bus write at the held offset. A read of the data window becomes a register-bus read at that offset. Software first loads the pointer and then accesses the data window, as often as it needs to.

The register-bus side is a master port. It issues single-cycle strobes, and its slave is a synchronous array that returns read data one cycle after the read strobe. Neither side has a valid/ready handshake. Every forwarded transfer completes in a fixed number of cycles, so no back-pressure path exists and the IO master never waits. Read data on the IO side appears in the cycle after the read strobe. In every other cycle it is zero.

Top module: `ioport_regwin_bridge`

## Requirements
- R1: After reset the pointer is zero, io_rdata is zero and neither reg_wr nor reg_rd is asserted.
- R2: A write to IO offset 0 loads the pointer with io_wdata. Bits 1:0 are forced to zero, bits at or above ADDR_W are dropped, and no register-bus transfer is issued.
- R3: A read of IO offset 0 returns the pointer, zero-extended, on io_rdata in the following cycle.
- R4: A write to IO offset 4 asserts reg_wr in the same cycle, with reg_addr equal to the pointer and reg_wdata equal to io_wdata.
- R5: A read of IO offset 4 asserts reg_rd in the same cycle with reg_addr equal to the pointer. In the following cycle io_rdata equals reg_rdata.
- R6: Accesses to IO offsets 1, 2, 3, 5, 6 and 7 are ignored. A write leaves the pointer unchanged and issues no transfer. A read issues no transfer and returns zero in the following cycle.
- R7: When io_wr and io_rd are both high, only the write is performed, and io_rdata is zero in the following cycle.
- R8: io_rdata is zero in any cycle that does not follow an IO read.
- R9: A pointer write takes effect for a data-window access in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 3 | IO byte offset |
| io_wr | input | 1 | IO write strobe |
| io_rd | input | 1 | IO read strobe |
| io_wdata | input | 32 | IO write data |
| io_rdata | output | 32 | IO read data, valid the cycle after io_rd |
| reg_addr | output | ADDR_W | Register-bus byte offset |
| reg_wr | output | 1 | Register-bus write strobe |
| reg_rd | output | 1 | Register-bus read strobe |
| reg_wdata | output | 32 | Register-bus write data |
| reg_rdata | input | 32 | Register-bus read data, one cycle after reg_rd |

## Verification
The pointer is exercised with aligned, misaligned and over-wide values, which shows whether the low-bit masking and the truncation to ADDR_W are applied. Data-window writes and reads run in several patterns: a sweep across many offsets, back-to-back pointer-then-data sequences, and write-then-readback pairs. These patterns separate forwarding at a stale pointer from forwarding at the current one. Accesses at every unused offset and simultaneous read and write strobes show that these cases neither leak transfers nor disturb the pointer. Idle cycles between operations show that read data returns to zero.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int IO_AW    = 3;
  localparam int DW       = 32;
  localparam logic [IO_AW-1:0] OFS_PTR  = 3'd0;
  localparam logic [IO_AW-1:0] OFS_DATA = 3'd4;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_PTR  = 2'd1,
    WIN_DATA = 2'd2
  } win_e;
endpackage

// File: rtl/iowin_decode.sv
module iowin_decode
  import iowin_pkg::*;
(
  input  logic [IO_AW-1:0] addr,
  input  logic             wr,
  input  logic             rd,
  output win_e             win,
  output logic             do_wr,
  output logic             do_rd
);
  always_comb begin
    unique case (addr)
      OFS_PTR:  win = WIN_PTR;
      OFS_DATA: win = WIN_DATA;
      default:  win = WIN_NONE;
    endcase
    do_wr = wr && (win != WIN_NONE);
    do_rd = rd && !wr && (win != WIN_NONE);
  end
endmodule

// File: rtl/iowin_pointer.sv
module iowin_pointer
  import iowin_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DW-1:0]     wdata,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= {wdata[ADDR_W-1:2], 2'b00};
  end

  assert_ptr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ptr));
endmodule

// File: rtl/iowin_return.sv
module iowin_return
  import iowin_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  win_e              rd_win,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [DW-1:0]     bus_rdata,
  output logic [DW-1:0]     rdata
);
  win_e              sel_q;
  logic [ADDR_W-1:0] ptr_cap;
  logic [DW-1:0]     ptr_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= WIN_NONE;
      ptr_cap <= '0;
    end else begin
      sel_q   <= rd_go ? rd_win : WIN_NONE;
      ptr_cap <= ptr;
    end
  end

  always_comb begin
    ptr_ext = '0;
    ptr_ext[ADDR_W-1:0] = ptr_cap;
    unique case (sel_q)
      WIN_PTR:  rdata = ptr_ext;
      WIN_DATA: rdata = bus_rdata;
      default:  rdata = '0;
    endcase
  end

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> (rdata == '0));
endmodule

// File: rtl/ioport_regwin_bridge.sv
module ioport_regwin_bridge
  import iowin_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [31:0]       io_wdata,
  output logic [31:0]       io_rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [31:0]       reg_wdata,
  input  logic [31:0]       reg_rdata
);
  win_e              win;
  logic              do_wr, do_rd;
  logic [ADDR_W-1:0] ptr;

  iowin_decode u_dec (
    .addr(io_addr), .wr(io_wr), .rd(io_rd),
    .win(win), .do_wr(do_wr), .do_rd(do_rd)
  );

  iowin_pointer #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(do_wr && win == WIN_PTR),
    .wdata(io_wdata), .ptr(ptr)
  );

  iowin_return #(.ADDR_W(ADDR_W)) u_ret (
    .clk(clk), .rst_n(rst_n),
    .rd_go(do_rd), .rd_win(win), .ptr(ptr),
    .bus_rdata(reg_rdata), .rdata(io_rdata)
  );

  assign reg_addr  = ptr;
  assign reg_wdata = io_wdata;
  assign reg_wr    = do_wr && win == WIN_DATA;
  assign reg_rd    = do_rd && win == WIN_DATA;

  assert_fwd_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> (reg_addr[1:0] == 2'b00));
  assert_unused_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr[1:0] != 2'b00) |-> (!reg_wr && !reg_rd));
  assert_both_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_rd) |=> (io_rdata == 32'd0));
endmodule

// File: tb/ioport_regwin_bridge_test.sv
module ioport_regwin_bridge_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    io_addr = '0;
  logic          io_wr = 1'b0, io_rd = 1'b0;
  logic [31:0]   io_wdata = '0;
  logic [31:0]   io_rdata;
  logic [AW-1:0] reg_addr;
  logic          reg_wr, reg_rd;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata = '0;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ioport_regwin_bridge #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // backing register file: synchronous array, 64 dwords
  logic [31:0] regfile [64];
  initial for (int i = 0; i < 64; i++) regfile[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
  always @(posedge clk) begin
    if (reg_wr) regfile[reg_addr[7:2]] <= reg_wdata;
    if (reg_rd) reg_rdata <= regfile[reg_addr[7:2]];
  end

  // reference model state
  int unsigned mptr = 0;
  int unsigned mmem [int unsigned];
  logic [31:0] exp_rd = '0;
  string       exp_tag = "R1";

  function automatic logic [31:0] model_read(int unsigned a);
    if (mmem.exists(a)) return mmem[a];
    return 32'hA500_0000 ^ ((a >> 2) * 32'h0101_0101);
  endfunction

  task automatic check(string tag, string lbl, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h exp %h", tag, lbl, got, exp);
    end
  endtask

  task automatic step(logic [2:0] a, logic w, logic r, logic [31:0] d, string lbl);
    string tag;
    logic  ewr, erd;
    @(negedge clk);
    check(exp_tag, {lbl, " io_rdata"}, io_rdata, exp_rd);
    io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
    #1;
    tag = (w && r) ? "R7" : (a != 3'd0 && a != 3'd4) ? "R6" : w ? "R4" : "R5";
    ewr = w && a == 3'd4;
    erd = r && !w && a == 3'd4;
    check(tag, {lbl, " reg_wr"}, 32'(reg_wr), 32'(ewr));
    check(tag, {lbl, " reg_rd"}, 32'(reg_rd), 32'(erd));
    if (ewr || erd) check("R9", {lbl, " reg_addr"}, 32'(reg_addr), mptr);
    if (ewr) check("R4", {lbl, " reg_wdata"}, reg_wdata, d);
    @(posedge clk);
    if (r && !w && a == 3'd0)      begin exp_rd = mptr;              exp_tag = "R3"; end
    else if (r && !w && a == 3'd4) begin exp_rd = model_read(mptr);  exp_tag = "R5"; end
    else begin
      exp_rd = '0;
      exp_tag = (w && r) ? "R7" : r ? "R6" : "R8";
    end
    if (w && a == 3'd0) mptr = d & 32'h0000_FFFC;
    if (w && a == 3'd4) mmem[mptr] = d;
  endtask

  task automatic idle(string lbl);
    step(3'd0, 1'b0, 1'b0, 32'd0, lbl);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "reset io_rdata", io_rdata, 32'd0);
    check("R1", "reset reg_wr", 32'(reg_wr), 32'd0);
    check("R1", "reset reg_rd", 32'(reg_rd), 32'd0);
    rst_n = 1'b1;
    step(3'd0, 1'b0, 1'b1, 32'd0, "R1 ptr after reset");
    idle("R3 ptr readback");
    // R2 pointer load and masking
    step(3'd0, 1'b1, 1'b0, 32'h10, "R2 load");
    step(3'd0, 1'b0, 1'b1, 32'd0, "R3 read");
    step(3'd0, 1'b1, 1'b0, 32'h13, "R2 misaligned");
    step(3'd0, 1'b0, 1'b1, 32'd0, "R2 masked");
    step(3'd0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R2 wide");
    step(3'd0, 1'b0, 1'b1, 32'd0, "R2 truncated");
    // R5 / R4 data window
    step(3'd0, 1'b1, 1'b0, 32'h20, "R9 set");
    step(3'd4, 1'b0, 1'b1, 32'd0, "R5 init read");
    step(3'd4, 1'b1, 1'b0, 32'hDEAD_BEEF, "R4 write");
    step(3'd4, 1'b0, 1'b1, 32'd0, "R5 readback");
    idle("R8 idle");
    // R6 unused offsets
    for (int k = 1; k < 8; k++) begin
      if (k == 4) continue;
      step(3'(k), 1'b1, 1'b0, 32'h5555_0000 + k, "R6 wr");
      step(3'(k), 1'b0, 1'b1, 32'd0, "R6 rd");
    end
    step(3'd0, 1'b0, 1'b1, 32'd0, "R6 ptr kept");
    step(3'd4, 1'b0, 1'b1, 32'd0, "R6 data kept");
    // R7 both strobes
    step(3'd4, 1'b1, 1'b1, 32'hCAFE_0001, "R7 both data");
    step(3'd0, 1'b1, 1'b1, 32'h48, "R7 both ptr");
    step(3'd4, 1'b0, 1'b1, 32'd0, "R7 after");
    // R9 back-to-back pointer then data
    step(3'd0, 1'b1, 1'b0, 32'h40, "R9 p1");
    step(3'd4, 1'b1, 1'b0, 32'h0000_1234, "R9 w1");
    step(3'd0, 1'b1, 1'b0, 32'h44, "R9 p2");
    step(3'd4, 1'b1, 1'b0, 32'h0000_5678, "R9 w2");
    step(3'd0, 1'b1, 1'b0, 32'h40, "R9 p3");
    step(3'd4, 1'b0, 1'b1, 32'd0, "R9 r1");
    step(3'd0, 1'b1, 1'b0, 32'h44, "R9 p4");
    step(3'd4, 1'b0, 1'b1, 32'd0, "R9 r2");
    // sweep
    for (int i = 0; i < 16; i++) begin
      step(3'd0, 1'b1, 1'b0, 32'(i * 8), "R4 sweep ptr");
      step(3'd4, 1'b1, 1'b0, 32'h1000_0000 * 32'(i) + 32'(i), "R4 sweep wr");
      idle("R8 sweep gap");
    end
    for (int i = 0; i < 16; i++) begin
      step(3'd0, 1'b1, 1'b0, 32'(i * 8), "R5 sweep ptr");
      step(3'd4, 1'b0, 1'b1, 32'd0, "R5 sweep rd");
    end
    idle("R8 final");
    idle("R8 final2");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule